// File: doc/BRIEF.md
# Buffer RAM with SECDED Protection and Zero-Fill Engine

This block wraps a buffer RAM with single-error-correct, double-error-detect (SECDED) coding. It has one or two access ports onto a shared word array. Each port has a hardware sweep engine that writes every word with zero data and matching check bits. Software starts a sweep after reset, so that no read can return check bits that do not match their data.

A small register interface controls the block. Through it software turns ECC checking on, starts each port's sweep and polls its completion, and sets or clears the correctable-error interrupt enable without a read-modify-write. It also selects whether each correctable error is recorded, clears sticky error flags by writing ones, and injects errors for testing. An injected error is either forced straight into a flag, or it corrupts the stored data bits of later port A writes. The normal bring-up order is as follows: clear the interrupt enable and the ECC enable, run the sweep(s), then set the mode, the ECC enable and the interrupt enable.

Top module: `eccmem_wrap`

## Requirements
- R1: After reset, every register reads 0, both busy outputs are 0, both rvalid outputs are 0 and irq is 0.
- R2: Writing the control register (0x08) with bit 8 set starts the port A sweep and clears init-status bit 0 (0x0C). Port A busy is high while the sweep runs. The sweep writes one word per clock, at addresses 0 to DEPTH-1. Init-status bit 0 reads 1 exactly DEPTH+1 clock edges after the edge that captured the start write. Busy is low from that edge on.
- R3: After a sweep, every word reads back as zero data and raises no error flag.
- R4: While a port is busy, its writes are dropped and its reads return no rvalid.
- R5: A read request captured at a clock edge presents rdata with rvalid high after that same edge. A write followed by a read of the same address returns the written data.
- R6: With ECC enabled, a read of a word with one flipped bit returns the corrected data. If mode bit 0 (0x1C) is 1, the read also sets the correctable flag for its port on the next edge: status bit 0 for port A, bit 16 for port B. If the mode bit is 0, no flag is set.
- R7: With ECC enabled, a read of a word with two flipped bits returns the stored data uncorrected. The read sets the uncorrectable flag for its port, whatever the mode: status bit 8 for port A, bit 24 for port B.
- R8: With control bit 0 cleared, reads return the stored data bits unchecked and set no flag.
- R9: Status flags (0x20) are sticky. Writing a 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R10: Writing 0x14 with bit 0 set turns the correctable-error interrupt enable on. Writing 0x18 with bit 0 set turns it off. The enable reads back at 0x10, bit 0. Writes with bit 0 clear have no effect.
- R11: irq is high when any correctable flag is set and the enable is on, or when any uncorrectable flag is set.
- R12: Writing the test register (0x24) with bit 0 or bit 8 set forces the port A correctable or uncorrectable flag. Test bit 4 makes later port A writes store data bit 0 inverted. Test bit 12 makes them store data bits 0 and 1 inverted.
- R13: Port B has its own sweep, started by control bit 16 and reported in init-status bit 8 with the same timing. Port B reads the shared array and reports errors in its own flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_busy | output | 1 | Port A sweep running, accesses dropped |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_busy | output | 1 | Port B sweep running, accesses dropped |
| irq | output | 1 | Error interrupt |

## Verification
Register writes take effect at the edge that captures them, so the bench reads registers back one step after each write task. Read data and rvalid are due right after the edge that captures the request. Error flags and irq follow one edge later, so the bench advances one clock after each read before it samples the status register. Sweep completion is timed by counting edges from the start write: completion must still read 0 after DEPTH edges and must read 1 after DEPTH+1. The bench also issues port accesses in the middle of the sweep, to show that they are dropped.

// File: rtl/eccw_pkg.sv
package eccw_pkg;
  localparam logic [7:0] OFS_CTRL    = 8'h08;
  localparam logic [7:0] OFS_INIT    = 8'h0C;
  localparam logic [7:0] OFS_IEN     = 8'h10;
  localparam logic [7:0] OFS_IEN_SET = 8'h14;
  localparam logic [7:0] OFS_IEN_CLR = 8'h18;
  localparam logic [7:0] OFS_MODE    = 8'h1C;
  localparam logic [7:0] OFS_STAT    = 8'h20;
  localparam logic [7:0] OFS_TEST    = 8'h24;

  localparam int CB_EN   = 0;
  localparam int CB_GO_A = 8;
  localparam int CB_GO_B = 16;
  localparam int SB_A    = 0;
  localparam int DB_A    = 8;
  localparam int SB_B    = 16;
  localparam int DB_B    = 24;
  localparam int TB_FSB  = 0;
  localparam int TB_FDB  = 8;
  localparam int TB_FL1  = 4;
  localparam int TB_FL2  = 12;

  typedef enum logic [1:0] {SWP_IDLE, SWP_RUN, SWP_LAST} swp_state_e;

  // number of Hamming check bits for a given data width (overall parity excluded)
  function automatic int secded_pbits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc import eccw_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                      din,
  output logic [DATA_W+secded_pbits(DATA_W):0]   cw_out
);
  localparam int P = secded_pbits(DATA_W);
  localparam int N = DATA_W + P;

  // codeword index k holds Hamming position k; index 0 holds overall parity
  always_comb begin
    int  di;
    logic par;
    cw_out = '0;
    di = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw_out[pos] = din[di];
        di++;
      end
    end
    for (int i = 0; i < P; i++) begin
      par = 1'b0;
      for (int pos = 1; pos <= N; pos++) begin
        if ((((pos >> i) & 1) == 1) && ((pos & (pos - 1)) != 0)) par = par ^ cw_out[pos];
      end
      cw_out[1 << i] = par;
    end
    cw_out[0] = ^cw_out[N:1];
  end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec import eccw_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W+secded_pbits(DATA_W):0] cw_in,
  output logic [DATA_W-1:0]                    raw_data,
  output logic [DATA_W-1:0]                    fix_data,
  output logic                                 single_err,
  output logic                                 double_err
);
  localparam int P = secded_pbits(DATA_W);
  localparam int N = DATA_W + P;

  logic [P-1:0] syn;
  logic         odd;
  logic [N:0]   fixed;

  always_comb begin
    int di;
    syn = '0;
    for (int pos = 1; pos <= N; pos++) begin
      if (cw_in[pos]) syn = syn ^ P'(pos);
    end
    odd   = ^cw_in;
    fixed = cw_in;
    if (odd && (syn != '0) && (int'(syn) <= N)) fixed[syn] = ~fixed[syn];
    raw_data = '0;
    fix_data = '0;
    di = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        raw_data[di] = cw_in[pos];
        fix_data[di] = fixed[pos];
        di++;
      end
    end
    single_err = odd;
    double_err = !odd && (syn != '0);
  end
endmodule

// File: rtl/ecc_init_sweep.sv
module ecc_init_sweep import eccw_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          wr,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  swp_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    done_d  = done_q;
    if (start) begin
      state_d = SWP_RUN;
      addr_d  = '0;
      done_d  = 1'b0;
    end else begin
      case (state_q)
        SWP_RUN: begin
          if (addr_q == LAST_ADDR) state_d = SWP_LAST;
          else                     addr_d  = addr_q + AW'(1);
        end
        SWP_LAST: begin
          state_d = SWP_IDLE;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SWP_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != SWP_IDLE);
  assign wr   = (state_q == SWP_RUN);
  assign addr = addr_q;
  assign done = done_q;
endmodule

// File: rtl/ecc_ram.sv
module ecc_ram #(
  parameter int CW    = 39,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic          re_a,
  input  logic [AW-1:0] addr_a,
  input  logic [CW-1:0] wd_a,
  output logic [CW-1:0] rd_a,
  input  logic          we_b,
  input  logic          re_b,
  input  logic [AW-1:0] addr_b,
  input  logic [CW-1:0] wd_b,
  output logic [CW-1:0] rd_b
);
  logic [CW-1:0] mem [DEPTH];

  // same-address collision: port A write lands last
  always_ff @(posedge clk) begin
    if (we_b) mem[addr_b] <= wd_b;
    if (we_a) mem[addr_a] <= wd_a;
    if (re_a) rd_a <= mem[addr_a];
    if (re_b) rd_b <= mem[addr_b];
  end
endmodule

// File: rtl/eccmem_wrap.sv
module eccmem_wrap import eccw_pkg::*; #(
  parameter int  DATA_W    = 32,
  parameter int  DEPTH     = 64,
  parameter bit  DUAL_PORT = 1'b1,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              a_busy,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              b_busy,
  output logic              irq
);
  localparam int PB = secded_pbits(DATA_W);
  localparam int CW = DATA_W + PB + 1;
  localparam int NP = DUAL_PORT ? 2 : 1;
  // codeword indices 3 and 5 carry data bits 0 and 1
  localparam logic [CW-1:0] FLIP_ONE = CW'(1) << 3;
  localparam logic [CW-1:0] FLIP_TWO = (CW'(1) << 3) | (CW'(1) << 5);

  // control state
  logic       ecc_en_q, ecc_en_d;
  logic       sb_ien_q, sb_ien_d;
  logic       mode_q, mode_d;
  logic       inj1_q, inj1_d;
  logic       inj2_q, inj2_d;
  logic [1:0] sb_pend_q, sb_pend_d;
  logic [1:0] db_pend_q, db_pend_d;

  logic wr_ctrl, wr_iset, wr_iclr, wr_mode, wr_stat, wr_test;
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_iset = reg_wr && (reg_addr == OFS_IEN_SET);
  assign wr_iclr = reg_wr && (reg_addr == OFS_IEN_CLR);
  assign wr_mode = reg_wr && (reg_addr == OFS_MODE);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_test = reg_wr && (reg_addr == OFS_TEST);

  // per-port vectors
  logic [1:0]        preq, pwe, start, busy, init_done;
  logic [1:0]        ram_we, ram_re, prvalid, se_v, de_v;
  logic [AW-1:0]     paddr    [2];
  logic [DATA_W-1:0] pwdata   [2];
  logic [DATA_W-1:0] prdata   [2];
  logic [AW-1:0]     ram_addr [2];
  logic [CW-1:0]     ram_wd   [2];
  logic [CW-1:0]     ram_rd   [2];
  logic [CW-1:0]     flip_a;

  assign preq      = {b_req, a_req};
  assign pwe       = {b_we, a_we};
  assign paddr[0]  = a_addr;
  assign paddr[1]  = b_addr;
  assign pwdata[0] = a_wdata;
  assign pwdata[1] = b_wdata;
  assign start     = {wr_ctrl & reg_wdata[CB_GO_B], wr_ctrl & reg_wdata[CB_GO_A]};
  assign flip_a    = inj2_q ? FLIP_TWO : (inj1_q ? FLIP_ONE : '0);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g < NP) begin : g_port
      logic              s_busy, s_wr, s_done, rv_q, d_se, d_de;
      logic [AW-1:0]     s_addr;
      logic [DATA_W-1:0] enc_in, d_raw, d_fix;
      logic [CW-1:0]     enc_cw, flip;

      ecc_init_sweep #(.DEPTH(DEPTH)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start(start[g]),
        .busy(s_busy), .wr(s_wr), .addr(s_addr), .done(s_done)
      );

      assign enc_in = s_wr ? '0 : pwdata[g];
      ecc_secded_enc #(.DATA_W(DATA_W)) u_enc (.din(enc_in), .cw_out(enc_cw));

      assign flip        = (g == 0) ? flip_a : '0;
      assign busy[g]     = s_busy;
      assign init_done[g] = s_done;
      assign ram_we[g]   = s_wr | (preq[g] & pwe[g] & ~s_busy);
      assign ram_re[g]   = preq[g] & ~pwe[g] & ~s_busy;
      assign ram_addr[g] = s_wr ? s_addr : paddr[g];
      assign ram_wd[g]   = s_wr ? enc_cw : (enc_cw ^ flip);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv_q <= 1'b0;
        else        rv_q <= ram_re[g];
      end

      ecc_secded_dec #(.DATA_W(DATA_W)) u_dec (
        .cw_in(ram_rd[g]), .raw_data(d_raw), .fix_data(d_fix),
        .single_err(d_se), .double_err(d_de)
      );

      assign prvalid[g] = rv_q;
      assign se_v[g]    = d_se;
      assign de_v[g]    = d_de;
      assign prdata[g]  = ecc_en_q ? d_fix : d_raw;
    end else begin : g_tie
      assign busy[g]      = 1'b0;
      assign init_done[g] = 1'b0;
      assign ram_we[g]    = 1'b0;
      assign ram_re[g]    = 1'b0;
      assign ram_addr[g]  = '0;
      assign ram_wd[g]    = '0;
      assign prvalid[g]   = 1'b0;
      assign se_v[g]      = 1'b0;
      assign de_v[g]      = 1'b0;
      assign prdata[g]    = '0;
    end
  end

  ecc_ram #(.CW(CW), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .we_a(ram_we[0]), .re_a(ram_re[0]), .addr_a(ram_addr[0]), .wd_a(ram_wd[0]), .rd_a(ram_rd[0]),
    .we_b(ram_we[1]), .re_b(ram_re[1]), .addr_b(ram_addr[1]), .wd_b(ram_wd[1]), .rd_b(ram_rd[1])
  );

  // error events and sticky flags
  logic [1:0] sb_evt, db_evt, sb_clr, db_clr, sb_frc, db_frc;
  assign sb_evt = prvalid & se_v & {2{ecc_en_q & mode_q}};
  assign db_evt = prvalid & de_v & {2{ecc_en_q}};
  assign sb_clr = wr_stat ? {reg_wdata[SB_B], reg_wdata[SB_A]} : 2'b00;
  assign db_clr = wr_stat ? {reg_wdata[DB_B], reg_wdata[DB_A]} : 2'b00;
  assign sb_frc = {1'b0, wr_test & reg_wdata[TB_FSB]};
  assign db_frc = {1'b0, wr_test & reg_wdata[TB_FDB]};

  always_comb begin
    ecc_en_d  = wr_ctrl ? reg_wdata[CB_EN] : ecc_en_q;
    mode_d    = wr_mode ? reg_wdata[0] : mode_q;
    inj1_d    = wr_test ? reg_wdata[TB_FL1] : inj1_q;
    inj2_d    = wr_test ? reg_wdata[TB_FL2] : inj2_q;
    sb_ien_d  = sb_ien_q;
    if (wr_iset && reg_wdata[0])      sb_ien_d = 1'b1;
    else if (wr_iclr && reg_wdata[0]) sb_ien_d = 1'b0;
    sb_pend_d = (sb_pend_q & ~sb_clr) | sb_evt | sb_frc;
    db_pend_d = (db_pend_q & ~db_clr) | db_evt | db_frc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_en_q  <= 1'b0;
      sb_ien_q  <= 1'b0;
      mode_q    <= 1'b0;
      inj1_q    <= 1'b0;
      inj2_q    <= 1'b0;
      sb_pend_q <= 2'b00;
      db_pend_q <= 2'b00;
    end else begin
      ecc_en_q  <= ecc_en_d;
      sb_ien_q  <= sb_ien_d;
      mode_q    <= mode_d;
      inj1_q    <= inj1_d;
      inj2_q    <= inj2_d;
      sb_pend_q <= sb_pend_d;
      db_pend_q <= db_pend_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[CB_EN] = ecc_en_q;
      OFS_INIT: begin
        reg_rdata[0] = init_done[0];
        reg_rdata[8] = init_done[1];
      end
      OFS_IEN:  reg_rdata[0] = sb_ien_q;
      OFS_MODE: reg_rdata[0] = mode_q;
      OFS_STAT: begin
        reg_rdata[SB_A] = sb_pend_q[0];
        reg_rdata[DB_A] = db_pend_q[0];
        reg_rdata[SB_B] = sb_pend_q[1];
        reg_rdata[DB_B] = db_pend_q[1];
      end
      OFS_TEST: begin
        reg_rdata[TB_FL1] = inj1_q;
        reg_rdata[TB_FL2] = inj2_q;
      end
      default: ;
    endcase
  end

  assign irq      = (sb_ien_q & (|sb_pend_q)) | (|db_pend_q);
  assign a_rdata  = prdata[0];
  assign a_rvalid = prvalid[0];
  assign a_busy   = busy[0];
  assign b_rdata  = prdata[1];
  assign b_rvalid = prvalid[1];
  assign b_busy   = busy[1];

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;
endmodule

// File: rtl/eccmem_wrap_chk.sv
module eccmem_wrap_chk import eccw_pkg::*; #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_req,
  input logic          a_we,
  input logic          a_busy,
  input logic          a_rvalid,
  input logic          b_busy,
  input logic [1:0]    init_done,
  input logic [1:0]    sb_pend,
  input logic [1:0]    db_pend,
  input logic          irq,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic          wbit0
);
  a_r4_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    a_busy |=> !a_rvalid);

  a_r5_read_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && !a_we && !a_busy) |=> a_rvalid);

  a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_busy) |-> !init_done[0]);

  a_r2_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_busy) |-> init_done[0]);

  a_r13_b_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_busy) |-> init_done[1]);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_pend[0] && !(reg_wr && (reg_addr == OFS_STAT) && wbit0)) |=> sb_pend[0]);

  a_r11_db_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|db_pend) |-> irq);
endmodule

bind eccmem_wrap eccmem_wrap_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_we(a_we), .a_busy(a_busy),
  .a_rvalid(a_rvalid), .b_busy(b_busy), .init_done(init_done),
  .sb_pend(sb_pend_q), .db_pend(db_pend_q), .irq(irq),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit0(reg_wdata[0])
);

// File: tb/eccmem_wrap_tb.sv
module eccmem_wrap_tb;
  localparam int CLK_P  = 10;
  localparam int DW     = 32;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;

  typedef struct packed {
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  inj;
    logic [31:0] exp_data;
    logic        exp_sb;
    logic        exp_db;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{6'd3,  32'h12345678, 2'd0, 32'h12345678, 1'b0, 1'b0},
    '{6'd10, 32'hA5A5A5A5, 2'd1, 32'hA5A5A5A5, 1'b1, 1'b0},
    '{6'd63, 32'hFFFFFFFF, 2'd2, 32'hFFFFFFFC, 1'b0, 1'b1},
    '{6'd0,  32'h00000001, 2'd1, 32'h00000001, 1'b1, 1'b0},
    '{6'd20, 32'h80000000, 2'd2, 32'h80000003, 1'b0, 1'b1},
    '{6'd41, 32'h0F0F0F0F, 2'd0, 32'h0F0F0F0F, 1'b0, 1'b0}
  };

  logic          clk, rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          a_req, a_we, a_rvalid, a_busy;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wdata, a_rdata;
  logic          b_req, b_we, b_rvalid, b_busy;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  eccmem_wrap #(.DATA_W(DW), .DEPTH(DEPTH), .DUAL_PORT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_busy(a_busy),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_busy(b_busy),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic pwrite(input int p, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    if (p == 0) begin a_req = 1'b1; a_we = 1'b1; a_addr = ad; a_wdata = d; end
    else        begin b_req = 1'b1; b_we = 1'b1; b_addr = ad; b_wdata = d; end
    tick();
    a_req = 1'b0; b_req = 1'b0; a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic pread(input int p, input logic [AW-1:0] ad, output logic [DW-1:0] d, output logic v);
    if (p == 0) begin a_req = 1'b1; a_we = 1'b0; a_addr = ad; end
    else        begin b_req = 1'b1; b_we = 1'b0; b_addr = ad; end
    tick();
    a_req = 1'b0; b_req = 1'b0;
    d = (p == 0) ? a_rdata : b_rdata;
    v = (p == 0) ? a_rvalid : b_rvalid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [DW-1:0] d;
    logic rv;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    a_req = 1'b0; a_we = 1'b0; a_addr = '0; a_wdata = '0;
    b_req = 1'b0; b_we = 1'b0; b_addr = '0; b_wdata = '0;
    repeat (3) tick();
    // R1: reset state
    rreg(8'h08, v); chk("R1 ctrl", v, 0);
    rreg(8'h0C, v); chk("R1 init", v, 0);
    rreg(8'h10, v); chk("R1 ien", v, 0);
    rreg(8'h1C, v); chk("R1 mode", v, 0);
    rreg(8'h20, v); chk("R1 stat", v, 0);
    rreg(8'h24, v); chk("R1 test", v, 0);
    chk("R1 irq/busy/rvalid", {28'd0, irq, a_busy, b_busy, a_rvalid}, 0);
    rst_n = 1'b1;
    tick();

    // R2 / R4: sweep port A with ECC off, probe stalls mid-sweep
    wreg(8'h08, 32'h0000_0100);
    chk("R2 busy after start", {31'd0, a_busy}, 1);
    rreg(8'h0C, v); chk("R2 done cleared", v, 0);
    for (int i = 1; i <= DEPTH; i++) begin
      if (i == 10) begin a_req = 1'b1; a_we = 1'b1; a_addr = '0; a_wdata = 32'hDEADBEEF; end
      if (i == 12) begin a_req = 1'b1; a_we = 1'b0; a_addr = 6'd1; end
      tick();
      a_req = 1'b0; a_we = 1'b0;
      if (i == 12) chk("R4 no rvalid while busy", {31'd0, a_rvalid}, 0);
    end
    rreg(8'h0C, v); chk("R2 not done after DEPTH edges", v, 0);
    tick();
    rreg(8'h0C, v); chk("R2 done after DEPTH+1 edges", v, 32'h1);
    chk("R2 busy low", {31'd0, a_busy}, 0);
    pread(0, 6'd0, d, rv); chk("R4 write dropped", d, 0);

    // R10: interrupt enable set/clear
    wreg(8'h14, 32'h0); rreg(8'h10, v); chk("R10 set with 0 ignored", v, 0);
    wreg(8'h14, 32'h1); rreg(8'h10, v); chk("R10 set", v, 1);
    wreg(8'h18, 32'h0); rreg(8'h10, v); chk("R10 clear with 0 ignored", v, 1);
    wreg(8'h1C, 32'h1);
    wreg(8'h08, 32'h1);

    // R13: port B sweep timing, A done kept
    wreg(8'h08, 32'h0001_0001);
    rreg(8'h0C, v); chk("R13 B done cleared", v, 32'h1);
    repeat (DEPTH) tick();
    rreg(8'h0C, v); chk("R13 B not done after DEPTH", v, 32'h1);
    tick();
    rreg(8'h0C, v); chk("R13 B done after DEPTH+1", v, 32'h101);

    // R3: zero contents, no flags
    pread(0, 6'd0, d, rv);  chk("R3 addr0", d, 0);
    pread(0, 6'd31, d, rv); chk("R3 addr31", d, 0);
    pread(1, 6'd63, d, rv); chk("R3 addr63 via B", d, 0);
    tick();
    rreg(8'h20, v); chk("R3 no flags", v, 0);

    // R5/R6/R7/R12: vector table with injection
    for (int k = 0; k < 6; k++) begin
      wreg(8'h24, (VECS[k].inj == 2'd1) ? 32'h10 : (VECS[k].inj == 2'd2) ? 32'h1000 : 32'h0);
      pwrite(0, VECS[k].addr, VECS[k].wdata);
      wreg(8'h24, 32'h0);
      pread(0, VECS[k].addr, d, rv);
      chk("R5 rvalid", {31'd0, rv}, 1);
      chk("R6/R7 rdata", d, VECS[k].exp_data);
      tick();
      rreg(8'h20, v);
      chk("R6/R7 flags", v, {23'd0, VECS[k].exp_db, 7'd0, VECS[k].exp_sb});
      chk("R11 irq", {31'd0, irq}, {31'd0, VECS[k].exp_sb | VECS[k].exp_db});
      wreg(8'h20, 32'h0000_0101);
      rreg(8'h20, v); chk("R9 cleared", v, 0);
    end

    // R6: mode 0 corrects silently
    wreg(8'h1C, 32'h0);
    wreg(8'h24, 32'h10);
    pwrite(0, 6'd7, 32'hCAFE0000);
    wreg(8'h24, 32'h0);
    pread(0, 6'd7, d, rv); chk("R6 mode0 corrected", d, 32'hCAFE0000);
    tick();
    rreg(8'h20, v); chk("R6 mode0 no flag", v, 0);

    // R8: bypass returns raw stored bits
    wreg(8'h1C, 32'h1);
    wreg(8'h08, 32'h0);
    pread(0, 6'd7, d, rv); chk("R8 raw data", d, 32'hCAFE0001);
    tick();
    rreg(8'h20, v); chk("R8 no flag", v, 0);
    wreg(8'h08, 32'h1);

    // R12 / R9: forced flags and write-one-to-clear
    wreg(8'h24, 32'h0000_0101);
    rreg(8'h20, v); chk("R12 forced flags", v, 32'h101);
    wreg(8'h20, 32'h1);
    rreg(8'h20, v); chk("R9 clear sb only", v, 32'h100);
    chk("R11 db keeps irq", {31'd0, irq}, 1);
    wreg(8'h20, 32'h0);
    rreg(8'h20, v); chk("R9 zero write no effect", v, 32'h100);
    wreg(8'h20, 32'h100);
    rreg(8'h20, v); chk("R9 clear db", v, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    // R11: enable gates correctable flag
    wreg(8'h24, 32'h1);
    chk("R11 sb with enable", {31'd0, irq}, 1);
    wreg(8'h18, 32'h1);
    chk("R11 sb without enable", {31'd0, irq}, 0);
    rreg(8'h20, v); chk("R11 flag kept", v, 1);
    wreg(8'h14, 32'h1);
    chk("R11 sb re-enabled", {31'd0, irq}, 1);
    wreg(8'h20, 32'h1);

    // R13: port B error flags
    wreg(8'h24, 32'h10);
    pwrite(0, 6'd15, 32'h13572468);
    wreg(8'h24, 32'h1000);
    pwrite(0, 6'd16, 32'h0000FFF0);
    wreg(8'h24, 32'h0);
    pread(1, 6'd15, d, rv); chk("R13 B corrected", d, 32'h13572468);
    chk("R13 B rvalid", {31'd0, rv}, 1);
    tick();
    rreg(8'h20, v); chk("R13 B sb flag", v, 32'h0001_0000);
    pread(1, 6'd16, d, rv); chk("R13 B uncorrected", d, 32'h0000FFF3);
    tick();
    rreg(8'h20, v); chk("R13 B db flag", v, 32'h0101_0000);
    wreg(8'h20, 32'h0101_0000);
    rreg(8'h20, v); chk("R13 B cleared", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule